// File: doc/BRIEF.md
# Two-Bit-Window Signed-Digit Recoder

This block turns an unsigned binary multiplier into a string of signed digits for a serial multiply unit that scans from the most significant end. Each enabled clock yields one digit, working downward from the top position. To form a digit it uses only the current bit, the bit just below it, and a single carry flag. It never inspects a third bit to find where a run of ones starts or ends. Where that leaves a chain boundary wrong, it emits a doubled digit of value ±2 at the neighbouring position instead, since a pair of adjacent unit digits is worth one radix-4 digit. The recoded word therefore has exactly as many digits as the operand, and the digits range over -2..2.

Together with every digit the block reports a zero-run count: how many zero digits come directly below the current position before the next nonzero digit, capped at what a k-stage barrel shifter can skip in one step. A one-cycle done pulse follows the last digit. A start request is taken only while the block is idle.

Top module: `msb_sd_recoder`

## Requirements
- R1: While reset is active and after it releases, with no start taken: digit_valid, done, digit and zero_run are all 0.
- R2: Carry c starts at 0 at the top position. For positions i = WIDTH-1 down to 1, the next carry is floor((c + b[i] + b[i-1]) / 2) and the digit is next carry + b[i] - 2c. The bottom digit is b[0] - 2c. Every digit lies in -2..2 and is driven on `digit` as 3-bit two's complement.
- R3: A run gives exactly WIDTH digits, one per enabled clock, at indices WIDTH-1, WIDTH-2, ..., 0 in that order. The sum of digit * 2^index over the run equals the loaded operand.
- R4: A start is taken on a clock edge where en is high and the block is idle. No digit is valid after that edge. The digit for index WIDTH-1 is valid after the next edge on which en is high.
- R5: On an edge where en is low, the recoding does not advance and digit_valid is 0 after that edge.
- R6: A start request while a recoding is in progress has no effect: the digits of the run in progress still sum to the operand loaded first.
- R7: done is 1 for exactly one cycle, the cycle after the digit at index 0 was valid. It is 0 at all other times.
- R8: With each valid digit at index i, zero_run gives the number of consecutive zero digits at positions i-1, i-2, ... before the first nonzero digit or the bottom of the operand, saturated at 2^SKIP_STAGES - 1. At index 0 it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Clock enable; the recoding advances one position per enabled edge |
| start | input | 1 | Load the operand and begin a recoding (idle only) |
| operand | input | WIDTH | Unsigned multiplier to recode |
| digit | output | 3 | Signed digit, two's complement, -2..2 |
| digit_valid | output | 1 | digit, digit_index and zero_run are valid this cycle |
| digit_index | output | $clog2(WIDTH) | Bit position of the current digit |
| zero_run | output | SKIP_STAGES | Zero digits directly below this one, saturated |
| done | output | 1 | One-cycle pulse after the index-0 digit |

## Verification
The bench sweeps every 8-bit operand twice. In the first pass en stays high, so the digit stream is uninterrupted. That pass separates correct carry handling, where the weighted sum matches, from an error at a chain boundary, where the sum or a single ±2 digit comes out wrong. It also covers long zero stretches such as 0x80 and 0x01, which push the zero-run count to saturation and to the bottom-of-operand stop. In the second pass en drops on every third edge and start is asserted throughout the run with a different operand. A digit index that advances while en is low, or a load taken while busy, then shows up as a wrong index sequence or a wrong sum. All 256 operands run through both passes.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  typedef logic signed [2:0] sdigit_t;
endpackage

// File: rtl/sdr_cell.sv
module sdr_cell
  import sdr_pkg::*;
(
  input  logic    carry_in,
  input  logic    bit_hi,
  input  logic    bit_lo,
  input  logic    last,
  output sdigit_t digit,
  output logic    carry_out
);
  logic [1:0] tally;
  logic       nxt;

  always_comb begin
    tally     = {1'b0, carry_in} + {1'b0, bit_hi} + {1'b0, bit_lo};
    nxt       = last ? 1'b0 : tally[1];
    carry_out = nxt;
    digit     = $signed({2'b00, nxt}) + $signed({2'b00, bit_hi})
              - $signed({1'b0, carry_in, 1'b0});
  end
endmodule

// File: rtl/sdr_lookahead.sv
module sdr_lookahead
  import sdr_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SKIP_STAGES = 3,
  localparam int LIM        = (1 << SKIP_STAGES) - 1,
  localparam int IDXW       = $clog2(WIDTH)
) (
  input  logic                   carry_in,
  input  logic [LIM:0]           bits,
  input  logic [IDXW-1:0]        pos,
  output logic [SKIP_STAGES-1:0] run
);
  logic    chain  [LIM+1];
  logic    exists [LIM];
  sdigit_t dig    [LIM];
  logic    halt;

  assign chain[0] = carry_in;

  for (genvar j = 0; j < LIM; j++) begin : g_peek
    assign exists[j] = (32'(pos) > j);
    sdr_cell u_cell (
      .carry_in  (chain[j]),
      .bit_hi    (bits[LIM-j]),
      .bit_lo    (bits[LIM-j-1]),
      .last      (32'(pos) == j + 1),
      .digit     (dig[j]),
      .carry_out (chain[j+1])
    );
  end

  always_comb begin
    run  = '0;
    halt = 1'b0;
    for (int j = 0; j < LIM; j++) begin
      if (!halt && exists[j] && dig[j] == 3'sd0) run = run + 1'b1;
      else                                       halt = 1'b1;
    end
  end
endmodule

// File: rtl/sdr_sequencer.sv
module sdr_sequencer #(
  parameter int WIDTH = 16,
  localparam int IDXW = $clog2(WIDTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            start,
  output logic            busy,
  output logic [IDXW-1:0] idx,
  output logic            load,
  output logic            step
);
  logic            busy_d;
  logic [IDXW-1:0] idx_d;

  assign load = en & start & ~busy;
  assign step = en & busy;

  always_comb begin
    busy_d = busy;
    idx_d  = idx;
    if (load) begin
      busy_d = 1'b1;
      idx_d  = IDXW'(WIDTH - 1);
    end else if (step) begin
      if (idx == '0) busy_d = 1'b0;
      else           idx_d  = idx - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else begin
      busy <= busy_d;
      idx  <= idx_d;
    end
  end

  // R3: positions are visited one below the other
  a_r3_index_descends: assert property (@(posedge clk) disable iff (!rst_n)
    (step && idx != '0) |=> (busy && idx == $past(idx) - 1'b1));

  // R6: a run in progress is not restarted before it reaches index 0
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx != '0 && start) |=> (busy && idx <= $past(idx)));
endmodule

// File: rtl/msb_sd_recoder.sv
module msb_sd_recoder
  import sdr_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SKIP_STAGES = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic                      start,
  input  logic [WIDTH-1:0]          operand,
  output logic signed [2:0]         digit,
  output logic                      digit_valid,
  output logic [$clog2(WIDTH)-1:0]  digit_index,
  output logic [SKIP_STAGES-1:0]    zero_run,
  output logic                      done
);
  localparam int IDXW = $clog2(WIDTH);
  localparam int LIM  = (1 << SKIP_STAGES) - 1;

  logic rs_meta, rs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  logic            busy, load, step;
  logic [IDXW-1:0] idx;

  sdr_sequencer #(.WIDTH(WIDTH)) u_seq (
    .clk   (clk),
    .rst_n (rs_n),
    .en    (en),
    .start (start),
    .busy  (busy),
    .idx   (idx),
    .load  (load),
    .step  (step)
  );

  logic [WIDTH-1:0] sreg, sreg_d;
  logic             carry, carry_d;
  sdigit_t          cur_digit;
  logic             cur_carry;

  sdr_cell u_cell (
    .carry_in  (carry),
    .bit_hi    (sreg[WIDTH-1]),
    .bit_lo    (sreg[WIDTH-2]),
    .last      (idx == '0),
    .digit     (cur_digit),
    .carry_out (cur_carry)
  );

  logic [LIM:0]           peek_bits;
  logic [SKIP_STAGES-1:0] cur_run;

  for (genvar j = 0; j <= LIM; j++) begin : g_peek_bits
    if (WIDTH - 2 - j >= 0) begin : g_in
      assign peek_bits[LIM-j] = sreg[WIDTH-2-j];
    end else begin : g_pad
      assign peek_bits[LIM-j] = 1'b0;
    end
  end

  sdr_lookahead #(.WIDTH(WIDTH), .SKIP_STAGES(SKIP_STAGES)) u_look (
    .carry_in (cur_carry),
    .bits     (peek_bits),
    .pos      (idx),
    .run      (cur_run)
  );

  always_comb begin
    sreg_d  = sreg;
    carry_d = carry;
    if (load) begin
      sreg_d  = operand;
      carry_d = 1'b0;
    end else if (step) begin
      sreg_d  = {sreg[WIDTH-2:0], 1'b0};
      carry_d = cur_carry;
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      sreg  <= '0;
      carry <= 1'b0;
    end else begin
      sreg  <= sreg_d;
      carry <= carry_d;
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      digit       <= '0;
      digit_index <= '0;
      zero_run    <= '0;
      digit_valid <= 1'b0;
      done        <= 1'b0;
    end else begin
      digit_valid <= step;
      done        <= digit_valid && digit_index == '0;
      if (step) begin
        digit       <= cur_digit;
        digit_index <= idx;
        zero_run    <= cur_run;
      end
    end
  end

  // R2: emitted digits stay within -2..2
  a_r2_digit_span: assert property (@(posedge clk) disable iff (!rs_n)
    digit_valid |-> (digit >= -3'sd2 && digit <= 3'sd2));

  // R5: no digit after an edge with the enable low
  a_r5_enable_gates: assert property (@(posedge clk) disable iff (!rs_n)
    !en |=> !digit_valid);

  // R7: done never lasts two cycles
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rs_n)
    done |=> !done);

  // R8: nothing lies below the bottom digit
  a_r8_bottom_run: assert property (@(posedge clk) disable iff (!rs_n)
    (digit_valid && digit_index == '0) |-> zero_run == '0);
endmodule

// File: tb/msb_sd_recoder_test.sv
module msb_sd_recoder_test;
  localparam int W   = 8;
  localparam int K   = 2;
  localparam int LIM = (1 << K) - 1;

  logic              clk = 1'b0;
  logic              rst_n, en, start;
  logic [W-1:0]      operand;
  logic signed [2:0] digit;
  logic              digit_valid, done;
  logic [2:0]        digit_index;
  logic [K-1:0]      zero_run;

  int checks   = 0;
  int failures = 0;

  always #10 clk = ~clk;

  msb_sd_recoder #(.WIDTH(W), .SKIP_STAGES(K)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .start       (start),
    .operand     (operand),
    .digit       (digit),
    .digit_valid (digit_valid),
    .digit_index (digit_index),
    .zero_run    (zero_run),
    .done        (done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_one(input logic [W-1:0] op, input bit gappy);
    int  d [W];
    int  c = 0;
    int  sum = 0;
    int  nxt = W - 1;
    int  remaining = W;
    bit  prev_en;
    bit  done_next = 0;
    bit  finished = 0;
    for (int i = W - 1; i >= 1; i--) begin
      int cn = (c + int'(op[i]) + int'(op[i-1])) / 2;
      d[i] = cn + int'(op[i]) - 2 * c;
      c = cn;
    end
    d[0] = int'(op[0]) - 2 * c;

    @(negedge clk);
    start = 1'b1; operand = op; en = 1'b1;
    @(negedge clk);
    chk(digit_valid == 1'b0, "R4 no digit on the load edge", int'(digit_valid), 0);
    start = 1'b0; operand = ~op; prev_en = 1'b1;

    for (int it = 0; it < 6 * W && !finished; it++) begin
      bit exp_valid;
      bit last_now;
      @(negedge clk);
      exp_valid = prev_en && remaining > 0;
      chk(digit_valid == exp_valid, "R5 digit_valid follows enable", int'(digit_valid), int'(exp_valid));
      chk(done == done_next, "R7 done timing", int'(done), int'(done_next));
      if (done_next) finished = 1;
      last_now = exp_valid && remaining == 1;
      if (exp_valid && digit_valid) begin
        int zr = 0;
        for (int p = nxt - 1; p >= 0 && d[p] == 0 && zr < LIM; p--) zr++;
        chk(int'(digit_index) == nxt, "R3 digit index order", int'(digit_index), nxt);
        chk(int'(digit) == d[nxt], "R2 digit value", int'(digit), d[nxt]);
        chk(int'(zero_run) == zr, "R8 zero run count", int'(zero_run), zr);
        sum += int'(digit) * (1 << int'(digit_index));
        nxt--;
        remaining--;
      end
      done_next = last_now;
      if (!finished) begin
        en      = gappy ? ((it % 3) != 1) : 1'b1;
        prev_en = en;
        start   = gappy && remaining >= 2;
      end
    end
    start = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R7 done lasts one cycle", int'(done), 0);
    chk(digit_valid == 1'b0, "R3 no digit after the last", int'(digit_valid), 0);
    chk(remaining == 0, "R3 digit count", W - remaining, W);
    chk(sum == int'(op), gappy ? "R6 sum with ignored starts" : "R3 weighted sum", sum, int'(op));
  endtask

  initial begin
    #(150000 * 20);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; start = 1'b0; operand = '0;
    repeat (3) @(negedge clk);
    chk(digit_valid == 1'b0 && done == 1'b0, "R1 outputs held in reset",
        int'(digit_valid) + int'(done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(digit_valid == 1'b0, "R1 digit_valid after reset", int'(digit_valid), 0);
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);
    chk(digit == 3'sd0, "R1 digit after reset", int'(digit), 0);
    chk(zero_run == '0, "R1 zero_run after reset", int'(zero_run), 0);
    for (int v = 0; v < 256; v++) run_one(W'(v), 1'b0);
    for (int v = 0; v < 256; v++) run_one(W'(v), 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule